// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a synchronous memory device. A board tester drives it with a test clock, a mode-select line and a serial data input, plus an optional active-low asynchronous reset. The tester moves a 16-state controller through the usual capture, shift and update sequences. The port shifts out of one serial output, which is paired with an enable that is high only while a register is actually being shifted.

A 3-bit instruction chooses which register sits between serial input and output. The choices are a 32-bit identification word, a single bypass bit, or a boundary-scan chain with one cell per monitored memory pin. The chain takes a parallel snapshot of the pin values and shifts new preload data in while the snapshot shifts out. An update stage then latches the preload data onto the cells' parallel outputs. Two of the instructions also raise an output-disable line that tells the memory to tristate its data outputs. Pin values are plain inputs, and the pad drivers are outside the block.

Top module: `scan_port_top`

## Requirements
- R1: The controller follows the standard 16-state sequence on rising test-clock edges, and five consecutive rising edges with mode-select high reach Test-Logic-Reset from any state.
- R2: After reset, and whenever Test-Logic-Reset is entered, the identification instruction (code 3'b001) is active. A data scan then returns the 32-bit identification word, least significant bit first.
- R3: The instruction register is 3 bits wide and is shifted least significant bit first. It captures 3'b001 in Capture-IR, and a shifted code becomes active only on the falling edge in Update-IR.
- R4: Code 3'b111 and the unassigned codes 3'b011, 3'b101 and 3'b110 all select a one-bit bypass register. That register captures 0, so a data scan returns 0 followed by the input bits delayed by one clock.
- R5: Code 3'b100 selects the boundary-scan chain. Capture-DR loads every pin value, and pin bit 0 is the first bit shifted out.
- R6: Preload bits shifted in during the same pass that shifts the snapshot out are copied to the parallel cell outputs on the falling edge in Update-DR, but only while code 3'b000, 3'b010 or 3'b100 is active. Under any other instruction those outputs do not change.
- R7: Code 3'b000 behaves exactly like 3'b100 and in addition raises the output-disable line.
- R8: Code 3'b010 selects the boundary-scan chain and holds output-disable high through all data scans and instruction shifting. The line drops only when a different instruction is applied at Update-IR, or when reset is entered.
- R9: The serial output changes only on falling test-clock edges. Its enable is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low port reset (tie high if unused) |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pinIn | input | NPINS | Monitored memory pin values |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdoEn | output | 1 | Serial output enable |
| outDisable | output | 1 | Request to tristate memory data outputs |
| bsrOut | output | NPINS | Latched parallel outputs of the boundary-scan cells |

## Verification
The hardest situation to provoke is an instruction change that is only half done. Output-disable must stay high while a new code is partly shifted and sitting in Exit1-IR, and drop only on the falling edge of the following Update-IR. The bench reaches it by loading the tristating instruction, then shifting a new code and sampling the disable line in the Exit1-IR clock and again after Update-IR. It also leaves that instruction through five mode-high clocks from Run-Test/Idle, and it samples the serial output between the rising and falling edge of a bypass shift to catch an output that moves on the wrong edge.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_t;

  localparam logic [IR_W-1:0] OP_ZSAMP   = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef struct packed {
    logic capDr;
    logic shDr;
    logic updDr;
    logic shIr;
    logic selBsr;
    logic selId;
    logic selByp;
  } tapStrobe_t;

endpackage

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapState_t  tapState,
  output tapStrobe_t strobe,
  output logic       irLsb,
  output logic       outDisable
);

  tapState_t nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] activeOp;
  logic bsrOp;

  always_comb begin
    case (tapState)
      TLR:     nextState = tms ? TLR    : RTI;
      RTI:     nextState = tms ? SEL_DR : RTI;
      SEL_DR:  nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nextState = tms ? EX1_DR : SH_DR;
      SH_DR:   nextState = tms ? EX1_DR : SH_DR;
      EX1_DR:  nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nextState = tms ? UPD_DR : SH_DR;
      UPD_DR:  nextState = tms ? SEL_DR : RTI;
      SEL_IR:  nextState = tms ? TLR    : CAP_IR;
      CAP_IR:  nextState = tms ? EX1_IR : SH_IR;
      SH_IR:   nextState = tms ? EX1_IR : SH_IR;
      EX1_IR:  nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nextState = tms ? UPD_IR : SH_IR;
      UPD_IR:  nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TLR;
    else        tapState <= nextState;
  end

  // instruction shift stage, LSB nearest the serial output
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                 irShift <= IR_CAPTURE;
    else if (tapState == CAP_IR) irShift <= IR_CAPTURE;
    else if (tapState == SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // active instruction changes only on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                  activeOp <= OP_IDCODE;
    else if (tapState == TLR)    activeOp <= OP_IDCODE;
    else if (tapState == UPD_IR) activeOp <= irShift;
  end

  always_comb begin
    bsrOp = (activeOp == OP_ZSAMP) || (activeOp == OP_SAMPZ) ||
            (activeOp == OP_SAMPLE);
    strobe.capDr  = (tapState == CAP_DR);
    strobe.shDr   = (tapState == SH_DR);
    strobe.updDr  = (tapState == UPD_DR);
    strobe.shIr   = (tapState == SH_IR);
    strobe.selBsr = bsrOp;
    strobe.selId  = (activeOp == OP_IDCODE);
    strobe.selByp = !bsrOp && (activeOp != OP_IDCODE);
  end

  assign irLsb      = irShift[0];
  assign outDisable = (activeOp == OP_ZSAMP) || (activeOp == OP_SAMPZ);

endmodule

// File: rtl/scan_port_dpath.sv
module scan_port_dpath
  import scan_port_pkg::*;
#(
  parameter int              NPINS   = 8,
  parameter logic [ID_W-1:0] ID_CODE = 32'h0A5C_3E49
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  tapStrobe_t       strobe,
  input  logic             irLsb,
  input  logic [NPINS-1:0] pinIn,
  output logic             tdo,
  output logic             tdoEn,
  output logic [NPINS-1:0] bsrOut
);

  logic            bypassBit;
  logic [ID_W-1:0] idShift;
  logic [NPINS-1:0] bsrShift;
  logic [NPINS:0]   bsrLink;
  logic            drLsb;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                             bypassBit <= 1'b0;
    else if (strobe.capDr && strobe.selByp) bypassBit <= 1'b0;
    else if (strobe.shDr && strobe.selByp)  bypassBit <= tdi;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                            idShift <= ID_CODE;
    else if (strobe.capDr && strobe.selId) idShift <= ID_CODE;
    else if (strobe.shDr && strobe.selId)  idShift <= {tdi, idShift[ID_W-1:1]};
  end

  // one boundary cell per monitored pin, chained toward cell 0
  assign bsrLink[NPINS] = tdi;
  for (genvar i = 0; i < NPINS; i++) begin : gCell
    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN)                             bsrShift[i] <= 1'b0;
      else if (strobe.capDr && strobe.selBsr) bsrShift[i] <= pinIn[i];
      else if (strobe.shDr && strobe.selBsr)  bsrShift[i] <= bsrLink[i+1];
    end
    assign bsrLink[i] = bsrShift[i];

    always_ff @(negedge tck or negedge trstN) begin
      if (!trstN)                             bsrOut[i] <= 1'b0;
      else if (strobe.updDr && strobe.selBsr) bsrOut[i] <= bsrShift[i];
    end
  end

  always_comb begin
    if (strobe.selBsr)     drLsb = bsrLink[0];
    else if (strobe.selId) drLsb = idShift[0];
    else                   drLsb = bypassBit;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shIr || strobe.shDr;
      if (strobe.shIr)      tdo <= irLsb;
      else if (strobe.shDr) tdo <= drLsb;
    end
  end

endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
  import scan_port_pkg::*;
#(
  parameter int              NPINS   = 8,
  parameter logic [ID_W-1:0] ID_CODE = 32'h0A5C_3E49
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  input  logic [NPINS-1:0] pinIn,
  output logic             tdo,
  output logic             tdoEn,
  output logic             outDisable,
  output logic [NPINS-1:0] bsrOut
);

  tapState_t  tapState;
  tapStrobe_t strobe;
  logic       irLsb;

  scan_port_ctrl uCtrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tapState(tapState), .strobe(strobe), .irLsb(irLsb),
    .outDisable(outDisable)
  );

  scan_port_dpath #(.NPINS(NPINS), .ID_CODE(ID_CODE)) uDpath (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobe(strobe), .irLsb(irLsb),
    .pinIn(pinIn), .tdo(tdo), .tdoEn(tdoEn), .bsrOut(bsrOut)
  );

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic             tck,
  input logic             trstN,
  input logic             tms,
  input logic             tdoEn,
  input logic             outDisable,
  input logic [NPINS-1:0] bsrOut,
  input tapState_t        tapState,
  input logic [2:0]       selVec
);

  logic [2:0] tmsRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)     tmsRun <= 3'd0;
    else if (!tms)  tmsRun <= 3'd0;
    else if (tmsRun != 3'd7) tmsRun <= tmsRun + 3'd1;
  end

  p_five_high_reset_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun >= 3'd5) |-> (tapState == TLR));

  p_one_register_selected_r4: assert property (@(posedge tck) disable iff (!trstN)
    $countones(selVec) == 1);

  p_bsr_moves_in_update_r6: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(bsrOut) |-> (tapState == UPD_DR));

  p_disable_moves_in_update_r8: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(outDisable) |-> (tapState == UPD_IR || tapState == TLR));

  p_enable_only_shifting_r9: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (tapState == SH_DR || tapState == SH_IR));

endmodule

bind scan_port_top scan_port_chk #(.NPINS(NPINS)) uChk (
  .tck(tck), .trstN(trstN), .tms(tms), .tdoEn(tdoEn),
  .outDisable(outDisable), .bsrOut(bsrOut), .tapState(tapState),
  .selVec({strobe.selBsr, strobe.selId, strobe.selByp})
);

// File: tb/tb_scan_port_top.sv
module tb_scan_port_top;

  localparam int NPINS = 8;
  localparam logic [31:0] IDV = 32'h0A5C_3E49;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [NPINS-1:0] pinIn = '0;
  logic tdo, tdoEn, outDisable;
  logic [NPINS-1:0] bsrOut;
  int nChk = 0, nFail = 0;
  logic [NPINS-1:0] bsrModel = '0;
  bit finished = 0;

  scan_port_top #(.NPINS(NPINS), .ID_CODE(IDV)) dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .pinIn(pinIn),
    .tdo(tdo), .tdoEn(tdoEn), .outDisable(outDisable), .bsrOut(bsrOut)
  );

  always #4 tck = ~tck;

  // {code, pins, shifted pattern}
  localparam logic [42:0] VEC [0:7] = '{
    {3'b100, 8'hA5, 32'h3C12_9A77},
    {3'b001, 8'h0F, 32'hFFFF_0000},
    {3'b000, 8'h5A, 32'hC3E1_0F55},
    {3'b111, 8'hFF, 32'h8000_0001},
    {3'b010, 8'h81, 32'h6600_3311},
    {3'b011, 8'h33, 32'h1234_5678},
    {3'b101, 8'hC0, 32'hDEAD_BEEF},
    {3'b110, 8'h18, 32'hA5A5_5A5A}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scanIr(logic [2:0] code, output logic [2:0] cap, output logic preDis);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, code[i]);
    end
    preDis = outDisable;
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanDr(logic [31:0] pat, output logic [31:0] got);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R9 enable in Shift-DR", 32'(tdoEn), 32'd1);
    for (int i = 0; i < 32; i++) begin
      got[i] = tdo;
      tick(i == 31, pat[i]);
    end
    tick(1, 0); tick(0, 0);
    chk("R9 enable off in idle", 32'(tdoEn), 32'd0);
  endtask

  function automatic bit isBsr(logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b100;
  endfunction

  function automatic logic [31:0] expScan(logic [2:0] code, logic [7:0] pins, logic [31:0] pat);
    int len; logic [31:0] cap; logic [31:0] r;
    if (isBsr(code))        begin len = 8;  cap = {24'h0, pins}; end
    else if (code == 3'b001) begin len = 32; cap = IDV; end
    else                     begin len = 1;  cap = 32'h0; end
    for (int i = 0; i < 32; i++) begin
      if (i < len) r[i] = cap[i];
      else         r[i] = pat[i-len];
    end
    return r;
  endfunction

  initial begin
    logic [2:0] cap, code;
    logic pre;
    logic [31:0] got, pat;
    string req;
    repeat (2) @(negedge tck);
    #1 trstN = 1'b1;
    // reset state
    chk("R9 enable after reset", 32'(tdoEn), 32'd0);
    chk("R8 disable low after reset", 32'(outDisable), 32'd0);
    chk("R6 cell outputs after reset", 32'(bsrOut), 32'd0);
    tick(0, 0);
    scanDr(32'h0, got);
    chk("R2 default identification", got, IDV);

    // vector table
    for (int v = 0; v < 8; v++) begin
      code = VEC[v][42:40];
      pinIn = VEC[v][39:32];
      pat = VEC[v][31:0];
      if (code == 3'b100)      req = "R5";
      else if (code == 3'b000) req = "R7";
      else if (code == 3'b010) req = "R8";
      else if (code == 3'b001) req = "R2";
      else                     req = "R4";
      scanIr(code, cap, pre);
      chk("R3 captured instruction pattern", 32'(cap), 32'h1);
      chk({req, " output-disable level"}, 32'(outDisable),
          32'(code == 3'b000 || code == 3'b010));
      scanDr(pat, got);
      chk({req, " scan data"}, got, expScan(code, pinIn, pat));
      if (isBsr(code)) bsrModel = pat[31:24];
      chk("R6 cell parallel outputs", 32'(bsrOut), 32'(bsrModel));
    end

    // SAMPLE Z held until a new instruction is applied
    scanIr(3'b010, cap, pre);
    chk("R8 disable raised", 32'(outDisable), 32'd1);
    scanDr(32'h0F00_0000, got);
    bsrModel = 8'h0F;
    chk("R8 disable held over data scan", 32'(outDisable), 32'd1);
    scanIr(3'b100, cap, pre);
    chk("R8 disable held before Update-IR", 32'(pre), 32'd1);
    chk("R3 new code applied at Update-IR", 32'(outDisable), 32'd0);

    // five mode-high clocks reach reset and restore identification
    scanIr(3'b010, cap, pre);
    for (int k = 0; k < 5; k++) tick(1, 0);
    chk("R1 reset reached, disable released", 32'(outDisable), 32'd0);
    chk("R9 enable off in reset", 32'(tdoEn), 32'd0);
    chk("R6 outputs kept through reset path", 32'(bsrOut), 32'(bsrModel));
    tick(0, 0);
    scanDr(32'h0, got);
    chk("R1 identification after five-high reset", got, IDV);

    // output edge: bypass, capture 0, shift in 1
    scanIr(3'b111, cap, pre);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R4 bypass capture bit", 32'(tdo), 32'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R9 output holds past rising edge", 32'(tdo), 32'd0);
    @(negedge tck); #1;
    chk("R9 output moves on falling edge", 32'(tdo), 32'd1);
    tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R6 bypass update leaves cells", 32'(bsrOut), 32'(bsrModel));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule